// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupt sources and a CPU. Pulse-type sources set a pending flag on a one-cycle event. The flag stays set while that source is masked, until it is served or until software clears it. Level-type sources have no flag and request service only while their input is high. Each source has its own enable bit, and one global enable bit gates every source.

When the global enable is set and at least one enabled source is pending, the block raises a request to the CPU. The request carries the vector of the winning source: the lowest-numbered source wins, and source i gets vector i+1 because vector 0 is kept for reset. When the CPU acknowledges, the block clears the global enable and the served flag at that clock edge. A return strobe from the CPU sets the global enable again. Software can also set the global enable inside a handler, which allows nesting. Saving the CPU status on entry is left to software.

A small register port lets software write the enables, clear flags by writing ones, and read or write the global enable.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the enable register, the flag register and the global enable all read 0, `irq_req` is 0 and `irq_vec` is 0.
- R2: A one-cycle high on `evt_i[i]` of a pulse-type source sets flag i at the next edge. This happens whatever the local and global enables are. The flag holds until it is served or cleared.
- R3: `irq_req` is high exactly when the global enable is set and some enabled source is pending. `irq_vec` then equals i+1 for the lowest pending enabled index i. `irq_vec` is 0 while `irq_req` is low.
- R4: A cycle with `irq_req` and `cpu_ack` both high clears the global enable and the flag of the selected source at that edge. Exactly one vector is taken per acknowledge.
- R5: `reti` high sets the global enable at the next edge. If an accepted acknowledge falls in the same cycle, the acknowledge wins and the global enable reads 0.
- R6: A software write of bit0=1 to the global enable register (address 2) enables requests again inside a handler, so a higher-priority source can interrupt it.
- R7: A write to address 1 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R8: If an event sets a flag in the same cycle that a software write or an acknowledge clears it, the flag ends up set.
- R9: Level-type sources (parameter `LVL_SRC`) never set a flag; their flag bits read 0. They request only while `lvl_i` is high and enabled. `lvl_i` of a pulse-type source has no effect.
- R10: `cpu_ack` while `irq_req` is low changes neither the flags nor the global enable.
- R11: Events that arrive while the global enable is 0 stay pending. Once the global enable is set they are served one at a time in priority order.

Register map (`reg_addr`): 0 holds the enables (read/write); 1 holds the flags (read, write-one-to-clear); 2 holds the global enable in bit0 (read/write); 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NSRC | One-cycle events from pulse-type sources |
| lvl_i | input | NSRC | Request levels from level-type sources |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Register read data (combinational) |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | $clog2(NSRC+1) | Vector of the winning source, 0 when idle |
| cpu_ack | input | 1 | CPU accepts the current request |
| reti | input | 1 | Return-from-interrupt strobe |

## Verification
Single events on masked sources show that flags are latched independently of the enables. Several events that arrive while the global enable is clear show that they are served one acknowledge at a time, lowest index first. Events that land in the same cycle as a software clear or an acknowledge tell a set-dominant flag apart from a clear-dominant one. Driving the level input on both a level-type and a pulse-type source tells apart the bypass of the flag store from a leak into it. Acknowledge with nothing pending and acknowledge together with a return strobe expose wrong priority in the global-enable update.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC = 4,
  parameter logic [NSRC-1:0] LVL_SRC = 4'b1000,
  localparam int VW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] lvl_i,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec,
  input  logic            cpu_ack,
  input  logic            reti
);

  logic [NSRC-1:0] flags, en, pend, sel_oh;
  logic [VW-1:0]   vec_raw;
  logic            gie;

  wire take = irq_req & cpu_ack;
  wire [NSRC-1:0] sw_clr  = (reg_we && reg_addr == 2'd1) ? reg_wdata : '0;
  wire [NSRC-1:0] ack_clr = take ? sel_oh : '0;

  assign pend    = (flags | (lvl_i & LVL_SRC)) & en;
  assign irq_req = gie & (|pend);
  assign irq_vec = irq_req ? vec_raw : '0;

  always_comb begin
    sel_oh  = '0;
    vec_raw = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel_oh  = NSRC'(1) << i;
        vec_raw = VW'(i + 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
      gie   <= 1'b0;
    end else begin
      flags <= ((flags & ~sw_clr & ~ack_clr) | evt_i) & ~LVL_SRC;
      if (reg_we && reg_addr == 2'd0) en <= reg_wdata;
      if (take)                               gie <= 1'b0;
      else if (reti)                          gie <= 1'b1;
      else if (reg_we && reg_addr == 2'd2)    gie <= reg_wdata[0];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = en;
      2'd1:    reg_rdata = flags;
      2'd2:    reg_rdata = NSRC'(gie);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NSRC = 4,
  parameter logic [NSRC-1:0] LVL_SRC = 4'b1000,
  localparam int VW = $clog2(NSRC + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt_i,
  input logic            cpu_ack,
  input logic            reti,
  input logic            irq_req,
  input logic [VW-1:0]   irq_vec,
  input logic [NSRC-1:0] flags,
  input logic            gie
);

  logic [NSRC-1:0] ack_bit;
  assign ack_bit = (irq_vec == '0) ? '0 : (NSRC'(1) << (irq_vec - VW'(1)));

  assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec != '0 && int'(irq_vec) <= NSRC));

  assert_take_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && cpu_ack) |=> (!gie && !irq_req));

  assert_served_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && cpu_ack) |=> ((flags & $past(ack_bit) & ~$past(evt_i)) == '0));

  assert_reti_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(irq_req && cpu_ack)) |=> gie);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & ~LVL_SRC) != '0) |=> ((flags & $past(evt_i) & ~LVL_SRC) == ($past(evt_i) & ~LVL_SRC)));

  assert_level_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & LVL_SRC) == '0);

  assert_idle_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !irq_req && !reti && gie) |=> gie);

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NSRC(NSRC), .LVL_SRC(LVL_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cpu_ack(cpu_ack), .reti(reti),
  .irq_req(irq_req), .irq_vec(irq_vec), .flags(flags), .gie(gie)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int NSRC = 4;
  localparam int VW = $clog2(NSRC + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] evt_i = '0, lvl_i = '0, reg_wdata = '0;
  logic            reg_we = 1'b0, cpu_ack = 1'b0, reti = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic [NSRC-1:0] reg_rdata;
  logic            irq_req;
  logic [VW-1:0]   irq_vec;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl #(.NSRC(NSRC), .LVL_SRC(4'b1000)) i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .cpu_ack(cpu_ack), .reti(reti)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = NSRC'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pulse_evt(input int m);
    @(negedge clk); evt_i = NSRC'(m);
    @(negedge clk); evt_i = '0;
  endtask

  task automatic ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic req_is(input int r, input int v, input string tag);
    #1; chk(int'(irq_req), r, tag); chk(int'(irq_vec), v, tag);
  endtask

  task automatic t_reset();
    int v;
    rd(2'd0, v); chk(v, 0, "R1 enables");
    rd(2'd1, v); chk(v, 0, "R1 flags");
    rd(2'd2, v); chk(v, 0, "R1 gie");
    req_is(0, 0, "R1 idle");
  endtask

  task automatic t_latch_masked();
    int v;
    wr(2'd2, 1);
    pulse_evt(4'b0100);
    rd(2'd1, v); chk(v, 4, "R2 flag latched while masked");
    req_is(0, 0, "R3 masked source gives no request");
    wr(2'd0, 4'b0111);
    req_is(1, 3, "R2 R3 held flag served once enabled");
    ack();
    rd(2'd1, v); chk(v, 0, "R4 served flag cleared");
    rd(2'd2, v); chk(v, 0, "R4 gie cleared on take");
    req_is(0, 0, "R4 no request after take");
    ret();
    rd(2'd2, v); chk(v, 1, "R5 reti sets gie");
  endtask

  task automatic t_priority();
    int v;
    wr(2'd2, 0);
    pulse_evt(4'b0110);
    rd(2'd1, v); chk(v, 6, "R11 both pending");
    req_is(0, 0, "R11 held while gie clear");
    wr(2'd2, 1);
    req_is(1, 2, "R11 source1 first");
    ack();
    rd(2'd1, v); chk(v, 4, "R4 only source1 cleared");
    ret();
    req_is(1, 3, "R11 source2 next");
    ack();
    rd(2'd1, v); chk(v, 0, "R4 source2 cleared");
    ret();
    req_is(0, 0, "R3 idle after both");
  endtask

  task automatic t_w1c();
    int v;
    wr(2'd2, 0);
    pulse_evt(4'b0111);
    wr(2'd1, 4'b0101);
    rd(2'd1, v); chk(v, 2, "R7 ones clear");
    wr(2'd1, 0);
    rd(2'd1, v); chk(v, 2, "R7 zeros keep");
    wr(2'd1, 4'b0010);
    rd(2'd1, v); chk(v, 0, "R7 last cleared");
  endtask

  task automatic t_set_wins();
    int v;
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 4'b0001; evt_i = 4'b0001;
    @(negedge clk); reg_we = 1'b0; evt_i = '0;
    rd(2'd1, v); chk(v, 1, "R8 set beats software clear");
    wr(2'd2, 1);
    req_is(1, 1, "R8 request on source0");
    @(negedge clk); cpu_ack = 1'b1; evt_i = 4'b0001;
    @(negedge clk); cpu_ack = 1'b0; evt_i = '0;
    rd(2'd1, v); chk(v, 1, "R8 set beats ack clear");
    rd(2'd2, v); chk(v, 0, "R4 gie cleared");
    wr(2'd1, 4'b0001);
    ret();
  endtask

  task automatic t_level();
    int v;
    wr(2'd0, 4'b1111);
    @(negedge clk); lvl_i = 4'b1000;
    req_is(1, 4, "R9 level source requests");
    rd(2'd1, v); chk(v, 0, "R9 level source has no flag");
    @(negedge clk); lvl_i = 4'b0000;
    req_is(0, 0, "R9 request drops with level");
    @(negedge clk); lvl_i = 4'b0001;
    @(negedge clk);
    req_is(0, 0, "R9 level on pulse source ignored");
    rd(2'd1, v); chk(v, 0, "R9 no flag from level on pulse source");
    @(negedge clk); lvl_i = '0;
  endtask

  task automatic t_nest();
    int v;
    pulse_evt(4'b0100);
    req_is(1, 3, "R6 handler for source2");
    ack();
    pulse_evt(4'b0001);
    req_is(0, 0, "R11 source0 waits while gie clear");
    wr(2'd2, 1);
    req_is(1, 1, "R6 nesting after software sets gie");
    ack();
    ret();
    rd(2'd1, v); chk(v, 0, "R6 all served");
  endtask

  task automatic t_ack_idle();
    int v;
    req_is(0, 0, "R10 idle");
    ack();
    rd(2'd2, v); chk(v, 1, "R10 ack while idle keeps gie");
    pulse_evt(4'b0010);
    @(negedge clk); cpu_ack = 1'b1; reti = 1'b1;
    @(negedge clk); cpu_ack = 1'b0; reti = 1'b0;
    rd(2'd2, v); chk(v, 0, "R5 take wins over reti");
    rd(2'd1, v); chk(v, 0, "R4 flag cleared with reti");
    rd(2'd3, v); chk(v, 0, "R1 unused address reads 0");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch_masked();
    t_priority();
    t_w1c();
    t_set_wins();
    t_level();
    t_nest();
    t_ack_idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule